// File: doc/BRIEF.md
# Programmable System Address Decoder

This block turns a 32-bit system bus address into a one-hot select for every external-memory and virtual region of a 4 GB map. A second output gives the offset of the address inside the selected region, and a third output flags addresses that hit nothing. The coarse map uses the top five address bits. These bits split the space into 1 GB quarters, and each quarter holds eight 128 MB blocks. Inside that coarse map, a bank of chip-select windows can be programmed at run time. Eight windows serve flash/SRAM and live in the lowest quarter. Two windows serve SDRAM and live in the third quarter.

A 1 MB boot page at 0x4000_0000 is steered by a boot strap. It goes either to the on-chip boot ROM or into the flash/SRAM window space. Two fixed virtual frame-buffer regions get their own selects: 256 MB in the second quarter and 512 MB in the fourth quarter. A simple write port programs the window registers. The outputs are registered and appear one clock after a valid address.

Top module: `sysmap_decoder`

## Requirements
- R1: The outputs are registered. Each output reflects the address presented with `addr_vld` high one clock edge earlier. After any edge where `addr_vld` was low, `sel` and `ofs` are zero and `dec_err` is low. All outputs are zero after reset.
- R2: `sel` is at most one-hot, with the following bit layout:
  - bits [7:0]: flash/SRAM chip-selects 0..7
  - bits [9:8]: SDRAM chip-selects 0..1
  - bit 10: boot ROM
  - bit 11: low frame-buffer region
  - bit 12: high frame-buffer region

  For a valid address, exactly one of two things is true: one `sel` bit is set, or `dec_err` is high.
- R3: Flash/SRAM window i hits when it is enabled, the address lies in the lowest quarter, and the address lies in [base, base+size). Size code 0/1/2/3 means 16/32/64/128 MB. `ofs` is the address minus the window base.
- R4: SDRAM window 0 has its base fixed at 0x8000_0000. SDRAM window 1 has a programmable base that resets to 0xA000_0000. SDRAM size code 0/1/2/3 means 64/128/256/512 MB. A hit also requires the address to lie in 0x8000_0000–0xBFFF_FFFF. `ofs` is the address minus the base.
- R5: When enabled windows overlap, the lowest-numbered one wins. Flash/SRAM windows rank before SDRAM windows.
- R6: With `boot_rom`=1, addresses 0x4000_0000–0x400F_FFFF select the boot ROM with `ofs` = addr[19:0]. With `boot_rom`=0, an address in that page is decoded as the address addr[19:0] through the flash/SRAM windows.
- R7: Addresses 0x7000_0000–0x7FFF_FFFF select the low frame-buffer region with `ofs` = addr − 0x7000_0000. Addresses 0xE000_0000–0xFFFF_FFFF select the high region with `ofs` = addr − 0xE000_0000.
- R8: Any valid address that matches no enabled window and no fixed region raises `dec_err` and drives `sel` and `ofs` to zero. Reserved blocks are included.
- R9: The reset configuration is as follows:
  - flash/SRAM window 0 is enabled, with base 0 and 128 MB size;
  - all other windows are disabled;
  - both SDRAM windows have size code 3.
- R10: A write with `wr_en` high programs one window; the new setting applies from the next clock edge.
  - `wr_idx` 0..7 addresses flash/SRAM window 0..7, and `wr_idx` 8..9 addresses SDRAM window 0..1.
  - `wr_data`[31:24] gives the base address bits [31:24].
  - `wr_data`[8] is the enable bit.
  - `wr_data`[1:0] is the size code.
- R11: Some writes are ignored entirely, and the window keeps all of its old fields:
  - a flash/SRAM write whose `wr_data`[31:30] is not 00;
  - an SDRAM window 1 write whose `wr_data`[31:30] is not 10.

  For SDRAM window 0, the base field of a write is discarded, but its enable and size fields are still taken.
- R12: Base bits below the window size are ignored. The effective base is the programmed base rounded down to a multiple of the window size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_vld | input | 1 | Address strobe |
| addr | input | 32 | System address |
| boot_rom | input | 1 | Boot strap: 1 = ROM boot, 0 = flash boot |
| wr_en | input | 1 | Window register write strobe |
| wr_idx | input | 4 | Window index (0..7 flash/SRAM, 8..9 SDRAM) |
| wr_data | input | 32 | Base[31:24], enable[8], size code[1:0] |
| sel | output | 13 | One-hot target select |
| ofs | output | 32 | Offset inside the selected region |
| dec_err | output | 1 | No target matched |

## Verification
The bench builds the block with its default parameters: eight flash/SRAM windows and two SDRAM windows. It sweeps all 32 coarse blocks under both strap values. Under each of the four size codes it walks the lowest quarter in 8 MB steps with every flash/SRAM window active, and it walks the third quarter for the SDRAM windows. This reaches every window edge, every reserved block and the boot-page redirect. Directed cases cover the following against a bench-side arithmetic model of the map:
- overlapping windows;
- unaligned bases;
- disabled windows;
- rejected base writes.

// File: rtl/sysmap_pkg.sv
package sysmap_pkg;
  localparam int AW = 32;

  // coarse block codes taken from address bits [31:27]
  localparam logic [4:0] BLK_BOOT  = 5'h08;
  localparam logic [4:0] BLK_VLO_A = 5'h0E;
  localparam logic [4:0] BLK_VLO_B = 5'h0F;
  localparam logic [11:0] BOOT_PAGE = 12'h400;

  // log2 of the smallest window in 16 MB units
  localparam int FLASH_FLOOR = 0;
  localparam int SDRAM_FLOOR = 2;

  typedef struct packed {
    logic       en;
    logic [7:0] base;  // address bits [31:24]
    logic [1:0] size;
  } cs_cfg_t;
endpackage

// File: rtl/sysmap_cs_regs.sv
module sysmap_cs_regs
  import sysmap_pkg::*;
#(
  parameter int N_FCS = 8,
  parameter int N_DCS = 2,
  localparam int IW = $clog2(N_FCS + N_DCS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [31:0]            wr_data,
  output cs_cfg_t [N_FCS-1:0]    fcs_cfg,
  output cs_cfg_t [N_DCS-1:0]    dcs_cfg
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[23:9], wr_data[7:2]};

  for (genvar i = 0; i < N_FCS; i++) begin : g_fcs
    always_ff @(posedge clk) begin
      if (rst) begin
        fcs_cfg[i] <= (i == 0) ? '{en: 1'b1, base: 8'h00, size: 2'b11} : '0;
      end else if (wr_en && wr_idx == IW'(i) && wr_data[31:30] == 2'b00) begin
        fcs_cfg[i] <= '{en: wr_data[8], base: wr_data[31:24], size: wr_data[1:0]};
      end
    end

    AST_FCS_IN_Q0: assert property (@(posedge clk) disable iff (rst)
      fcs_cfg[i].base[7:6] == 2'b00); // R11
  end

  for (genvar j = 0; j < N_DCS; j++) begin : g_dcs
    localparam bit FIXED = (j == 0);
    localparam logic [7:0] RST_BASE = FIXED ? 8'h80 : 8'hA0;
    logic take;
    assign take = wr_en && wr_idx == IW'(N_FCS + j) &&
                  (FIXED || wr_data[31:30] == 2'b10);

    always_ff @(posedge clk) begin
      if (rst) begin
        dcs_cfg[j] <= '{en: 1'b0, base: RST_BASE, size: 2'b11};
      end else if (take) begin
        dcs_cfg[j] <= '{en: wr_data[8],
                        base: FIXED ? RST_BASE : wr_data[31:24],
                        size: wr_data[1:0]};
      end
    end

    AST_DCS_IN_Q2: assert property (@(posedge clk) disable iff (rst)
      dcs_cfg[j].base[7:6] == 2'b10); // R11
  end
endmodule

// File: rtl/sysmap_win.sv
module sysmap_win
  import sysmap_pkg::*;
#(
  parameter int FLOOR = 0
) (
  input  logic [31:0] addr,
  input  cs_cfg_t     cfg,
  output logic        hit,
  output logic [31:0] ofs
);
  logic [7:0] mask;

  // bits of the base byte that take part in the compare
  assign mask = 8'hFF << (FLOOR + int'(cfg.size));
  assign hit  = cfg.en && (((addr[31:24] ^ cfg.base) & mask) == 8'h00);
  assign ofs  = {addr[31:24] & ~mask, addr[23:0]};
endmodule

// File: rtl/sysmap_pick.sv
module sysmap_pick #(
  parameter int N = 13,
  parameter int W = 32
) (
  input  logic [N-1:0]        hit,
  input  logic [N-1:0][W-1:0] ofs_in,
  output logic [N-1:0]        onehot,
  output logic [W-1:0]        ofs_out,
  output logic                any
);
  always_comb begin
    onehot  = '0;
    ofs_out = '0;
    any     = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit[k]) begin
        onehot    = '0;
        onehot[k] = 1'b1;
        ofs_out   = ofs_in[k];
        any       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysmap_decoder.sv
module sysmap_decoder
  import sysmap_pkg::*;
#(
  parameter int N_FCS = 8,
  parameter int N_DCS = 2,
  localparam int NT = N_FCS + N_DCS + 3,
  localparam int IW = $clog2(N_FCS + N_DCS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_vld,
  input  logic [31:0]   addr,
  input  logic          boot_rom,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  output logic [NT-1:0] sel,
  output logic [31:0]   ofs,
  output logic          dec_err
);
  localparam int ROM_I = N_FCS + N_DCS;
  localparam int VLO_I = ROM_I + 1;
  localparam int VHI_I = ROM_I + 2;

  cs_cfg_t [N_FCS-1:0] fcs_cfg;
  cs_cfg_t [N_DCS-1:0] dcs_cfg;

  sysmap_cs_regs #(.N_FCS(N_FCS), .N_DCS(N_DCS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .fcs_cfg(fcs_cfg), .dcs_cfg(dcs_cfg)
  );

  // boot page steering
  logic        in_boot;
  logic [31:0] eff_addr;
  logic [4:0]  blk;
  assign in_boot  = addr[31:20] == BOOT_PAGE;
  assign eff_addr = (in_boot && !boot_rom) ? {12'h000, addr[19:0]} : addr;
  assign blk      = eff_addr[31:27];

  logic in_q0, in_q2;
  assign in_q0 = blk[4:3] == 2'b00;
  assign in_q2 = blk[4:3] == 2'b10;

  logic [NT-1:0]        hit_all;
  logic [NT-1:0][31:0]  ofs_all;
  logic [N_FCS-1:0]     fcs_hit;
  logic [N_DCS-1:0]     dcs_hit;

  for (genvar i = 0; i < N_FCS; i++) begin : g_fwin
    sysmap_win #(.FLOOR(FLASH_FLOOR)) u_win (
      .addr(eff_addr), .cfg(fcs_cfg[i]), .hit(fcs_hit[i]), .ofs(ofs_all[i])
    );
    assign hit_all[i] = fcs_hit[i] & in_q0;
  end

  for (genvar j = 0; j < N_DCS; j++) begin : g_dwin
    sysmap_win #(.FLOOR(SDRAM_FLOOR)) u_win (
      .addr(eff_addr), .cfg(dcs_cfg[j]), .hit(dcs_hit[j]), .ofs(ofs_all[N_FCS+j])
    );
    assign hit_all[N_FCS+j] = dcs_hit[j] & in_q2;
  end

  assign hit_all[ROM_I] = in_boot && boot_rom;
  assign ofs_all[ROM_I] = {12'h000, addr[19:0]};
  assign hit_all[VLO_I] = (blk == BLK_VLO_A) || (blk == BLK_VLO_B);
  assign ofs_all[VLO_I] = {4'h0, eff_addr[27:0]};
  assign hit_all[VHI_I] = blk[4:2] == 3'b111;
  assign ofs_all[VHI_I] = {3'h0, eff_addr[28:0]};

  logic [NT-1:0] pick_sel;
  logic [31:0]   pick_ofs;
  logic          pick_any;

  sysmap_pick #(.N(NT), .W(32)) u_pick (
    .hit(hit_all), .ofs_in(ofs_all), .onehot(pick_sel),
    .ofs_out(pick_ofs), .any(pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst || !addr_vld) begin
      sel     <= '0;
      ofs     <= '0;
      dec_err <= 1'b0;
    end else begin
      sel     <= pick_sel;
      ofs     <= pick_ofs;
      dec_err <= !pick_any;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel)); // R2
  AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> (sel == '0 && ofs == '0)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !addr_vld |=> (sel == '0 && !dec_err)); // R1
  AST_ALWAYS_ANSWER: assert property (@(posedge clk) disable iff (rst)
    addr_vld |=> (dec_err || sel != '0)); // R2
  AST_ROM_BOOT: assert property (@(posedge clk) disable iff (rst)
    (addr_vld && boot_rom && addr[31:20] == BOOT_PAGE) |=> sel[ROM_I]); // R6
  AST_RSVD_Q3: assert property (@(posedge clk) disable iff (rst)
    (addr_vld && addr[31:29] == 3'b110) |=> dec_err); // R8
endmodule

// File: tb/sysmap_decoder_tb.sv
module sysmap_decoder_tb;
  localparam int NT = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_vld = 1'b0;
  logic [31:0] addr = '0;
  logic        boot_rom = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [NT-1:0] sel;
  logic [31:0] ofs;
  logic        dec_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sysmap_decoder u_dut (
    .clk(clk), .rst(rst), .addr_vld(addr_vld), .addr(addr), .boot_rom(boot_rom),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sel(sel), .ofs(ofs), .dec_err(dec_err)
  );

  // shadow of the window settings, kept by the bench from R9..R11
  bit         fen [8];
  logic [7:0] fb  [8];
  logic [1:0] fs  [8];
  bit         den [2];
  logic [7:0] db  [2];
  logic [1:0] ds  [2];

  task automatic shadow_reset();
    for (int i = 0; i < 8; i++) begin fen[i] = 0; fb[i] = 8'h00; fs[i] = 2'b00; end
    fen[0] = 1; fs[0] = 2'b11;
    den[0] = 0; db[0] = 8'h80; ds[0] = 2'b11;
    den[1] = 0; db[1] = 8'hA0; ds[1] = 2'b11;
  endtask

  function automatic void model(input logic [31:0] a, input bit rom,
                                output logic [NT-1:0] es, output logic [31:0] eo,
                                output bit ee);
    longint ea, base, size;
    es = '0; eo = '0; ee = 0;
    ea = longint'(a);
    if (a[31:20] == 12'h400) begin
      if (rom) begin es[10] = 1; eo = a - 32'h4000_0000; return; end
      ea = longint'(a & 32'h000F_FFFF);
    end
    if (ea < 64'h4000_0000) begin
      for (int i = 0; i < 8; i++) begin
        size = longint'(1) << (24 + fs[i]);
        base = longint'(fb[i]) << 24;
        base = base - (base % size);
        if (fen[i] && ea >= base && ea < base + size) begin
          es[i] = 1; eo = 32'(ea - base); return;
        end
      end
    end
    if (ea >= 64'h8000_0000 && ea < 64'hC000_0000) begin
      for (int j = 0; j < 2; j++) begin
        size = longint'(1) << (26 + ds[j]);
        base = longint'(db[j]) << 24;
        base = base - (base % size);
        if (den[j] && ea >= base && ea < base + size) begin
          es[8 + j] = 1; eo = 32'(ea - base); return;
        end
      end
    end
    if (ea >= 64'h7000_0000 && ea < 64'h8000_0000) begin
      es[11] = 1; eo = 32'(ea - 64'h7000_0000); return;
    end
    if (ea >= 64'hE000_0000) begin
      es[12] = 1; eo = 32'(ea - 64'hE000_0000); return;
    end
    ee = 1;
  endfunction

  function automatic string auto_tag(input logic [NT-1:0] es, input bit ee);
    if (ee) return "R8";
    if (es[10]) return "R6";
    if (es[11] || es[12]) return "R7";
    if (es[9:8] != 0) return "R4";
    return "R3";
  endfunction

  task automatic wr(input int idx, input logic [7:0] base, input bit en, input logic [1:0] sz);
    logic [31:0] d;
    d = {base, 15'h0, en, 6'h0, sz};
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (idx < 8) begin
      if (base[7:6] == 2'b00) begin fen[idx] = en; fb[idx] = base; fs[idx] = sz; end
    end else if (idx == 8) begin
      den[0] = en; ds[0] = sz;
    end else if (base[7:6] == 2'b10) begin
      den[1] = en; db[1] = base; ds[1] = sz;
    end
  endtask

  task automatic dec(input logic [31:0] a, input bit rom, input string tag);
    logic [NT-1:0] es; logic [31:0] eo; bit ee; string t;
    @(negedge clk);
    addr = a; boot_rom = rom; addr_vld = 1;
    @(negedge clk);
    addr_vld = 0;
    model(a, rom, es, eo, ee);
    t = (tag == "") ? auto_tag(es, ee) : tag;
    checks++;
    if (sel !== es || ofs !== eo || dec_err !== ee) begin
      errors++;
      $display("FAIL %s addr=%h rom=%0d: sel=%b ofs=%h err=%b expected sel=%b ofs=%h err=%b",
               t, a, rom, sel, ofs, dec_err, es, eo, ee);
    end
  endtask

  task automatic chk_idle(input string tag);
    checks++;
    if (sel !== '0 || ofs !== '0 || dec_err !== 1'b0) begin
      errors++;
      $display("FAIL %s idle: sel=%b ofs=%h err=%b expected all zero", tag, sel, ofs, dec_err);
    end
  endtask

  task automatic disable_all();
    for (int i = 0; i < 8; i++) wr(i, 8'h00, 0, 2'b00);
    wr(8, 8'h80, 0, 2'b00);
    wr(9, 8'hA0, 0, 2'b00);
  endtask

  initial begin : watchdog
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int offs [6];
    offs = '{32'h0, 32'h000F_FFFF, 32'h0010_0000, 32'h0400_0000, 32'h07FF_FFF0, 32'h07FF_FFFF};
    shadow_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_idle("R1");                      // R1 reset outputs

    // R9 reset configuration
    dec(32'h07FF_FFFF, 1, "R9");
    dec(32'h0800_0000, 1, "R9");
    dec(32'h8000_0000, 1, "R9");
    dec(32'hA000_0000, 1, "R9");
    @(negedge clk);
    chk_idle("R1");                      // R1 output clears after an idle cycle

    // coarse sweep over all blocks, both straps (R6, R7, R8)
    for (int rom = 0; rom < 2; rom++)
      for (int b = 0; b < 32; b++)
        for (int k = 0; k < 6; k++)
          dec({5'(b), 27'h0} + 32'(offs[k]), bit'(rom), "");

    // flash/SRAM windows under every size code (R3, R10)
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 8; i++) wr(i, 8'(i * 8), 1, 2'(s));
      for (int k = 0; k < 128; k++) begin
        dec(32'(k) << 23, 0, "R3");
        dec((32'(k) << 23) + 32'h007F_FFFF, 0, "R3");
      end
      dec(32'h4000_1234, 0, "R6");       // flash boot redirect
      dec(32'h4000_1234, 1, "R6");
    end

    // R12 unaligned base, R5 overlap, R10 disable
    disable_all();
    wr(2, 8'h13, 1, 2'b11);
    dec(32'h1000_0000, 0, "R12");
    dec(32'h17FF_FFFF, 0, "R12");
    dec(32'h1800_0000, 0, "R12");
    wr(5, 8'h10, 1, 2'b10);
    dec(32'h1000_0040, 0, "R5");
    wr(2, 8'h13, 0, 2'b11);
    dec(32'h1000_0040, 0, "R5");
    wr(5, 8'h10, 0, 2'b10);
    dec(32'h1000_0040, 0, "R10");
    dec(32'h4000_0000, 0, "R10");        // redirect with no flash window: error

    // SDRAM windows under every size code (R4)
    for (int s = 0; s < 4; s++) begin
      wr(8, 8'h80, 1, 2'(s));
      wr(9, 8'hA0, 1, 2'(s));
      for (int k = 0; k < 32; k++) begin
        dec(32'h8000_0000 + (32'(k) << 25), 1, "R4");
        dec(32'h8000_0000 + (32'(k) << 25) - 1, 1, "R4");
      end
    end
    wr(8, 8'h80, 1, 2'b11);
    wr(9, 8'h90, 1, 2'b00);
    dec(32'h9000_0000, 1, "R5");         // SDRAM 0 outranks SDRAM 1
    wr(8, 8'h80, 1, 2'b00);
    dec(32'h9000_0000, 1, "R4");
    wr(9, 8'h8C, 1, 2'b01);
    dec(32'h8800_0000, 1, "R12");
    dec(32'h8FFF_FFFF, 1, "R12");
    dec(32'h9000_0000, 1, "R12");

    // R11 rejected writes
    wr(3, 8'h08, 1, 2'b00);
    wr(3, 8'h48, 1, 2'b11);              // out of lowest quarter: ignored
    dec(32'h0800_0000, 0, "R11");
    dec(32'h08FF_FFFF, 0, "R11");
    dec(32'h0900_0000, 0, "R11");
    wr(9, 8'h00, 0, 2'b11);              // out of third quarter: ignored
    dec(32'h8800_0000, 1, "R11");
    wr(8, 8'hC0, 1, 2'b01);              // base discarded, size taken
    dec(32'h8000_0000, 1, "R11");
    dec(32'h87FF_FFFF, 1, "R11");
    dec(32'hC000_0000, 1, "R11");

    @(negedge clk);
    chk_idle("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule